// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block gathers interrupt causes from the peripherals of a small microcontroller into one 8-bit flag register. Six of the bits are sticky event flags. A single-cycle pulse from a timer overflow, a timer period match, a capture/compare unit, a USB core summary line, an A/D converter or a parallel slave port sets its flag. The flag then stays set until software writes it back to zero. The remaining two bits track the buffer state of a serial port. One bit shows that the receive buffer holds a byte, and it clears as a side effect of reading the receive data register. The other shows that the transmit buffer is empty, and it clears as a side effect of writing the transmit data register.

Software reaches the block through a simple register port: a flag register, a per-bit enable mask, a control register that holds the global enable, a receive data window and a transmit data window. A flag latches whether or not it is enabled. The single interrupt request line is active only when the global enable is on and at least one set flag has its mask bit set. A build parameter removes the parallel slave port. In that build its bit is reserved and always reads as zero.

Top module: `pirq_flag_reg`

## Requirements
- R1: While `rst` is high at a clock edge, all flags, the mask, the global enable, `bus_rdata`, `tx_push` and `irq` become 0.
- R2: Bit positions of `flags`, from bit 7 down to bit 0, are: parallel port access, A/D done, receive full, transmit empty, USB, capture/compare, timer2 match, timer1 overflow. A one-cycle event pulse sets its bit, which is visible after that clock edge whatever the mask and global enable hold.
- R3: A sticky flag (bits 7, 6, 3, 2, 1, 0) holds its value until a write to the flag register (address 0). Such a write loads each sticky bit from `bus_wdata`, so writing 1 sets the bit and writing 0 clears it.
- R4: When a set event and a flag-register write of 0 hit the same sticky bit in the same cycle, the bit ends up set.
- R5: `ccp_mode` selects the capture/compare source: 0 = off, 1 = capture (`ccp_capture` sets bit 2), 2 = compare (`ccp_match` sets bit 2), 3 = PWM. In modes 0 and 3 neither pulse sets the bit.
- R6: Bit 5 sets on `ser_rx_arrive` and clears when address 3 is read. That read returns `ser_rx_byte`. If an arrival and the read happen in the same cycle, bit 5 stays set.
- R7: Bit 4 sets on `ser_tx_taken` and clears when address 4 is written. That write loads `tx_byte` from `bus_wdata` and raises `tx_push` for exactly one cycle. If the write and `ser_tx_taken` happen in the same cycle, bit 4 ends up clear.
- R8: Bits 5 and 4 ignore writes to the flag register.
- R9: With `HAS_PSP` = 0, bit 7 is always 0 and ignores both `psp_access` and flag-register writes.
- R10: `irq` equals the global enable (address 2, bit 0) ANDed with the OR over all bits of `flags & mask`. The mask is at address 1. `irq` stays high until the enabled flags are cleared or the enables are removed.
- R11: A read sets `bus_rdata` in the following cycle to the pre-edge value of the addressed register: 0 = flags, 1 = mask, 2 = {7'b0, global enable}, 3 = `ser_rx_byte`, and 0 for any other address. `bus_rdata` is 0 in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr1_ovf | input | 1 | Timer1 overflow pulse |
| tmr2_hit | input | 1 | Timer2 period match pulse |
| ccp_mode | input | 2 | Capture/compare mode code |
| ccp_capture | input | 1 | Capture event pulse |
| ccp_match | input | 1 | Compare match pulse |
| usb_event | input | 1 | USB core summary interrupt pulse |
| adc_done | input | 1 | A/D conversion complete pulse |
| psp_access | input | 1 | Parallel port read/write pulse |
| ser_rx_arrive | input | 1 | Byte arrived in receive buffer |
| ser_rx_byte | input | 8 | Receive buffer contents |
| ser_tx_taken | input | 1 | Transmit buffer emptied by shifter |
| tx_byte | output | 8 | Byte written to transmit window |
| tx_push | output | 1 | One-cycle strobe for a new transmit byte |
| flags | output | 8 | Current flag register |
| irq | output | 1 | Combined interrupt request |

## Verification
The most delicate collisions are a hardware event and a software access that reach the same bit in the same clock edge. For sticky bits the access is a flag write of 0 and the event wins. For the receive bit it is an arrival against a data read, and the arrival wins. For the transmit bit it is a shifter take against a data write, and the write wins. Directed steps drive each pair together in one cycle and check the resulting bit against the outcome each requirement fixes. The random phase produces many further coincidences, and a bench model that applies the same precedence judges every cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int FLAG_W = 8;

  // bit positions inside the flag register
  localparam int B_T1  = 0;
  localparam int B_T2  = 1;
  localparam int B_CCP = 2;
  localparam int B_USB = 3;
  localparam int B_TX  = 4;
  localparam int B_RX  = 5;
  localparam int B_ADC = 6;
  localparam int B_PSP = 7;

  // register addresses
  localparam int A_FLAG = 0;
  localparam int A_MASK = 1;
  localparam int A_CTRL = 2;
  localparam int A_RXD  = 3;
  localparam int A_TXD  = 4;

  typedef enum logic [1:0] {
    CCP_OFF     = 2'd0,
    CCP_CAPTURE = 2'd1,
    CCP_COMPARE = 2'd2,
    CCP_PWM     = 2'd3
  } ccp_mode_e;
endpackage

// File: rtl/pirq_flag_cell.sv
module pirq_flag_cell #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wr_i,
  input  logic wd_i,
  output logic q_o
);
  generate
    if (PRESENT) begin : g_live
      logic q;
      // hardware set has priority over a software write
      always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (wr_i)  q <= wd_i;
      end
      assign q_o = q;
    end else begin : g_reserved
      logic unused_cell;
      assign unused_cell = ^{clk, rst, set_i, wr_i, wd_i};
      assign q_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pirq_buf_status.sv
module pirq_buf_status (
  input  logic clk,
  input  logic rst,
  input  logic rx_arrive_i,
  input  logic rx_read_i,
  input  logic tx_taken_i,
  input  logic tx_write_i,
  output logic rx_full_o,
  output logic tx_empty_o
);
  // a new byte arriving while the old one is read leaves the buffer full
  always_ff @(posedge clk) begin
    if (rst)              rx_full_o <= 1'b0;
    else if (rx_arrive_i) rx_full_o <= 1'b1;
    else if (rx_read_i)   rx_full_o <= 1'b0;
  end

  // a fresh write refills the buffer even as the shifter drains it
  always_ff @(posedge clk) begin
    if (rst)             tx_empty_o <= 1'b0;
    else if (tx_write_i) tx_empty_o <= 1'b0;
    else if (tx_taken_i) tx_empty_o <= 1'b1;
  end
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs #(
  parameter int ADDR_W = 3,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      flags_i,
  input  logic [W-1:0]      rx_byte_i,
  output logic [W-1:0]      mask_o,
  output logic              gie_o,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      tx_byte_o,
  output logic              tx_push_o,
  output logic              flag_wr_o,
  output logic              rx_read_o,
  output logic              tx_write_o
);
  import pirq_pkg::*;

  logic sel_flag, sel_mask, sel_ctrl, sel_rxd, sel_txd;
  logic [W-1:0] rd_mux;

  assign sel_flag = (addr_i == ADDR_W'(A_FLAG));
  assign sel_mask = (addr_i == ADDR_W'(A_MASK));
  assign sel_ctrl = (addr_i == ADDR_W'(A_CTRL));
  assign sel_rxd  = (addr_i == ADDR_W'(A_RXD));
  assign sel_txd  = (addr_i == ADDR_W'(A_TXD));

  assign flag_wr_o  = wr_i & sel_flag;
  assign rx_read_o  = rd_i & sel_rxd;
  assign tx_write_o = wr_i & sel_txd;

  always_comb begin
    rd_mux = '0;
    if (sel_flag)      rd_mux = flags_i;
    else if (sel_mask) rd_mux = mask_o;
    else if (sel_ctrl) rd_mux = {{(W-1){1'b0}}, gie_o};
    else if (sel_rxd)  rd_mux = rx_byte_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o    <= '0;
      gie_o     <= 1'b0;
      rdata_o   <= '0;
      tx_byte_o <= '0;
      tx_push_o <= 1'b0;
    end else begin
      if (wr_i && sel_mask) mask_o <= wdata_i;
      if (wr_i && sel_ctrl) gie_o  <= wdata_i[0];
      if (tx_write_o)       tx_byte_o <= wdata_i;
      tx_push_o <= tx_write_o;
      rdata_o   <= rd_i ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/pirq_flag_reg.sv
module pirq_flag_reg #(
  parameter int ADDR_W  = 3,
  parameter bit HAS_PSP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tmr1_ovf,
  input  logic              tmr2_hit,
  input  logic [1:0]        ccp_mode,
  input  logic              ccp_capture,
  input  logic              ccp_match,
  input  logic              usb_event,
  input  logic              adc_done,
  input  logic              psp_access,
  input  logic              ser_rx_arrive,
  input  logic [7:0]        ser_rx_byte,
  input  logic              ser_tx_taken,
  output logic [7:0]        tx_byte,
  output logic              tx_push,
  output logic [7:0]        flags,
  output logic              irq
);
  import pirq_pkg::*;

  ccp_mode_e         mode;
  logic              ccp_fire;
  logic [FLAG_W-1:0] evt;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] mask;
  logic              gie;
  logic              flag_wr, rx_read, tx_write;

  assign mode     = ccp_mode_e'(ccp_mode);
  assign ccp_fire = ((mode == CCP_CAPTURE) && ccp_capture) ||
                    ((mode == CCP_COMPARE) && ccp_match);

  always_comb begin
    evt        = '0;
    evt[B_T1]  = tmr1_ovf;
    evt[B_T2]  = tmr2_hit;
    evt[B_CCP] = ccp_fire;
    evt[B_USB] = usb_event;
    evt[B_TX]  = ser_tx_taken;
    evt[B_RX]  = ser_rx_arrive;
    evt[B_ADC] = adc_done;
    evt[B_PSP] = psp_access;
  end

  genvar i;
  generate
    for (i = 0; i < FLAG_W; i++) begin : g_bit
      if (i != B_RX && i != B_TX) begin : g_sticky
        pirq_flag_cell #(
          .PRESENT((i == B_PSP) ? HAS_PSP : 1'b1)
        ) u_cell (
          .clk  (clk),
          .rst  (rst),
          .set_i(evt[i]),
          .wr_i (flag_wr),
          .wd_i (bus_wdata[i]),
          .q_o  (flag_q[i])
        );
      end
    end
  endgenerate

  pirq_buf_status u_buf (
    .clk        (clk),
    .rst        (rst),
    .rx_arrive_i(evt[B_RX]),
    .rx_read_i  (rx_read),
    .tx_taken_i (evt[B_TX]),
    .tx_write_i (tx_write),
    .rx_full_o  (flag_q[B_RX]),
    .tx_empty_o (flag_q[B_TX])
  );

  pirq_regs #(
    .ADDR_W(ADDR_W),
    .W     (FLAG_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (bus_addr),
    .wr_i      (bus_wr),
    .rd_i      (bus_rd),
    .wdata_i   (bus_wdata),
    .flags_i   (flag_q),
    .rx_byte_i (ser_rx_byte),
    .mask_o    (mask),
    .gie_o     (gie),
    .rdata_o   (bus_rdata),
    .tx_byte_o (tx_byte),
    .tx_push_o (tx_push),
    .flag_wr_o (flag_wr),
    .rx_read_o (rx_read),
    .tx_write_o(tx_write)
  );

  assign flags = flag_q;
  assign irq   = gie & (|(flag_q & mask));
endmodule

// File: rtl/pirq_flag_reg_chk.sv
module pirq_flag_reg_chk #(
  parameter int ADDR_W  = 3,
  parameter bit HAS_PSP = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              tmr1_ovf,
  input logic [1:0]        ccp_mode,
  input logic              ser_rx_arrive,
  input logic              ser_tx_taken,
  input logic [7:0]        flags,
  input logic              irq,
  input logic              tx_push
);
  import pirq_pkg::*;

  logic flag_write, rx_rd, tx_wr;
  assign flag_write = bus_wr && (bus_addr == ADDR_W'(A_FLAG));
  assign rx_rd      = bus_rd && (bus_addr == ADDR_W'(A_RXD));
  assign tx_wr      = bus_wr && (bus_addr == ADDR_W'(A_TXD));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags == 8'h00 && !irq && !tx_push));

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    tmr1_ovf |=> flags[B_T1]);

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[B_ADC] && !flag_write) |=> flags[B_ADC]);

  // R5
  ccp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ccp_mode == 2'd3 && !flags[B_CCP] && !flag_write) |=> !flags[B_CCP]);

  // R6
  rx_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && !ser_rx_arrive) |=> !flags[B_RX]);

  // R7
  tx_write_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> (!flags[B_TX] && tx_push));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[B_TX] && !tx_wr) |=> flags[B_TX]);

  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (flags == 8'h00) |-> !irq);

  generate
    if (!HAS_PSP) begin : g_nopsp
      // R9
      psp_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        !flags[B_PSP]);
    end
  endgenerate
endmodule

bind pirq_flag_reg pirq_flag_reg_chk #(
  .ADDR_W (ADDR_W),
  .HAS_PSP(HAS_PSP)
) u_chk (.*);

// File: tb/pirq_flag_reg_tb.sv
module pirq_flag_reg_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0] s_addr = '0;
  logic       s_wr = 0, s_rd = 0;
  logic [7:0] s_wd = '0;
  logic       s_t1 = 0, s_t2 = 0, s_cap = 0, s_mat = 0, s_usb = 0;
  logic       s_adc = 0, s_psp = 0, s_rxa = 0, s_txt = 0;
  logic [1:0] s_mode = '0;
  logic [7:0] s_rxb = '0;

  logic [7:0] rdata, txb, flg, rdata_n, txb_n, flg_n;
  logic       push, irq, push_n, irq_n;

  pirq_flag_reg #(.ADDR_W(3), .HAS_PSP(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(s_addr), .bus_wr(s_wr), .bus_rd(s_rd),
    .bus_wdata(s_wd), .bus_rdata(rdata), .tmr1_ovf(s_t1), .tmr2_hit(s_t2),
    .ccp_mode(s_mode), .ccp_capture(s_cap), .ccp_match(s_mat),
    .usb_event(s_usb), .adc_done(s_adc), .psp_access(s_psp),
    .ser_rx_arrive(s_rxa), .ser_rx_byte(s_rxb), .ser_tx_taken(s_txt),
    .tx_byte(txb), .tx_push(push), .flags(flg), .irq(irq));

  pirq_flag_reg #(.ADDR_W(3), .HAS_PSP(1'b0)) u_nopsp (
    .clk(clk), .rst(rst), .bus_addr(s_addr), .bus_wr(s_wr), .bus_rd(s_rd),
    .bus_wdata(s_wd), .bus_rdata(rdata_n), .tmr1_ovf(s_t1), .tmr2_hit(s_t2),
    .ccp_mode(s_mode), .ccp_capture(s_cap), .ccp_match(s_mat),
    .usb_event(s_usb), .adc_done(s_adc), .psp_access(s_psp),
    .ser_rx_arrive(s_rxa), .ser_rx_byte(s_rxb), .ser_tx_taken(s_txt),
    .tx_byte(txb_n), .tx_push(push_n), .flags(flg_n), .irq(irq_n));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_f = '0, m_fn = '0, m_mask = '0, m_rd = '0, m_txb = '0;
  logic       m_gie = 0, m_push = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] flag_next(input logic [7:0] f, input bit has_psp);
    logic [7:0] n;
    logic [7:0] ev;
    logic fw, fire;
    fw   = s_wr && s_addr == 3'd0;
    fire = (s_mode == 2'd1 && s_cap) || (s_mode == 2'd2 && s_mat);
    ev   = {s_psp, s_adc, 2'b00, s_usb, fire, s_t2, s_t1};
    n    = f;
    for (int i = 0; i < 8; i++)
      if (i != 4 && i != 5) n[i] = ev[i] | (fw ? s_wd[i] : f[i]);
    n[5] = s_rxa | (f[5] & !(s_rd && s_addr == 3'd3));
    n[4] = !(s_wr && s_addr == 3'd4) & (s_txt | f[4]);
    if (!has_psp) n[7] = 1'b0;
    return n;
  endfunction

  function automatic logic irq_of(input logic [7:0] f);
    return m_gie & (|(f & m_mask));
  endfunction

  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_f = '0; m_fn = '0; m_mask = '0; m_gie = 0; m_rd = '0; m_txb = '0; m_push = 0;
    end else begin
      logic [7:0] nf, nfn;
      nf  = flag_next(m_f, 1'b1);
      nfn = flag_next(m_fn, 1'b0);
      m_rd = '0;
      if (s_rd) begin
        case (s_addr)
          3'd0: m_rd = m_f;
          3'd1: m_rd = m_mask;
          3'd2: m_rd = {7'b0, m_gie};
          3'd3: m_rd = s_rxb;
          default: m_rd = '0;
        endcase
      end
      m_push = s_wr && s_addr == 3'd4;
      if (m_push) m_txb = s_wd;
      if (s_wr && s_addr == 3'd1) m_mask = s_wd;
      if (s_wr && s_addr == 3'd2) m_gie = s_wd[0];
      m_f = nf;
      m_fn = nfn;
    end
    @(negedge clk);
    chk("R3 flags vs model", flg, m_f);
    chk("R9 flags vs model (no port)", flg_n, m_fn);
    chk("R10 irq vs model", irq, irq_of(m_f));
    chk("R10 irq vs model (no port)", irq_n, irq_of(m_fn));
    chk("R11 rdata vs model", rdata, m_rd);
    chk("R7 tx_push vs model", push, m_push);
    chk("R7 tx_byte vs model", txb, m_txb);
  endtask

  task automatic idle();
    s_wr = 0; s_rd = 0; s_addr = '0; s_wd = '0;
    s_t1 = 0; s_t2 = 0; s_cap = 0; s_mat = 0; s_usb = 0;
    s_adc = 0; s_psp = 0; s_rxa = 0; s_txt = 0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    s_wr = 1; s_addr = a; s_wd = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    idle();
    rst = 1;
    step(); step();
    @(negedge clk); rst = 0;
    idle(); step();
    // R1 reset state
    chk("R1 flags after reset", flg, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 rdata after reset", rdata, 8'h00);

    // R2 flag latches with mask and global enable off
    s_adc = 1; step(); idle();
    chk("R2 A/D bit set while disabled", flg, 8'h40);
    chk("R2 irq stays low while disabled", irq, 1'b0);
    bus_write(3'd1, 8'h40); step(); idle();
    bus_write(3'd2, 8'h01); step(); idle();
    chk("R10 irq once enabled", irq, 1'b1);
    step();
    chk("R10 irq holds", irq, 1'b1);
    bus_write(3'd0, 8'h00); step(); idle();
    chk("R3 software clear", flg, 8'h00);
    chk("R10 irq drops after clear", irq, 1'b0);

    // R4 set wins over same-cycle clear
    s_t1 = 1; step(); idle();
    s_t1 = 1; bus_write(3'd0, 8'h00); step(); idle();
    chk("R4 set beats write of 0", flg[0], 1'b1);
    bus_write(3'd0, 8'h00); step(); idle();

    // R5 capture/compare mode gating
    s_mode = 2'd3; s_cap = 1; s_mat = 1; step(); idle();
    chk("R5 PWM mode never sets", flg[2], 1'b0);
    s_mode = 2'd0; s_cap = 1; s_mat = 1; step(); idle();
    chk("R5 off mode never sets", flg[2], 1'b0);
    s_mode = 2'd1; s_mat = 1; step(); idle();
    chk("R5 capture mode ignores match", flg[2], 1'b0);
    s_mode = 2'd1; s_cap = 1; step(); idle();
    chk("R5 capture sets", flg[2], 1'b1);
    bus_write(3'd0, 8'h00); step(); idle();
    s_mode = 2'd2; s_mat = 1; step(); idle();
    chk("R5 compare sets", flg[2], 1'b1);
    bus_write(3'd0, 8'h00); step(); idle();

    // R6 / R8 / R9 receive bit and write isolation
    s_rxb = 8'hA5; s_rxa = 1; step(); idle();
    chk("R6 receive bit set", flg[5], 1'b1);
    bus_write(3'd0, 8'hFF); step(); idle();
    chk("R8 flag write keeps rx/tx", flg, 8'hEF);
    chk("R9 reserved bit ignores write", flg_n, 8'h6F);
    s_psp = 1; step(); idle();
    chk("R9 reserved bit ignores event", flg_n[7], 1'b0);
    bus_write(3'd0, 8'h00); step(); idle();
    chk("R8 clear write spares rx", flg, 8'h20);
    s_rd = 1; s_addr = 3'd3; s_rxa = 1; step(); idle();
    chk("R6 arrival beats read", flg[5], 1'b1);
    chk("R11 receive window data", rdata, 8'hA5);
    s_rd = 1; s_addr = 3'd3; step(); idle();
    chk("R6 read clears receive bit", flg[5], 1'b0);

    // R7 transmit bit
    s_txt = 1; step(); idle();
    chk("R7 transmit empty set", flg[4], 1'b1);
    s_txt = 1; bus_write(3'd4, 8'h3C); step(); idle();
    chk("R7 write beats take", flg[4], 1'b0);
    chk("R7 push strobe", push, 1'b1);
    chk("R7 pushed byte", txb, 8'h3C);
    step();
    chk("R7 push is one cycle", push, 1'b0);

    // R11 unmapped address reads zero
    s_rd = 1; s_addr = 3'd6; step(); idle();
    chk("R11 unmapped read", rdata, 8'h00);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int op;
      idle();
      s_t1  = ($urandom % 8) == 0;
      s_t2  = ($urandom % 8) == 0;
      s_cap = ($urandom % 6) == 0;
      s_mat = ($urandom % 6) == 0;
      s_usb = ($urandom % 10) == 0;
      s_adc = ($urandom % 10) == 0;
      s_psp = ($urandom % 10) == 0;
      s_rxa = ($urandom % 7) == 0;
      s_txt = ($urandom % 7) == 0;
      s_mode = 2'($urandom % 4);
      s_rxb = 8'($urandom);
      op = int'($urandom % 4);
      s_addr = 3'($urandom % 6);
      s_wd = 8'($urandom);
      s_wr = (op == 0) || (op == 2);
      s_rd = (op == 1) || (op == 2);
      step();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule